// File: doc/BRIEF.md
# 128-bit Rotate, Shift and Mask Unit

This purely combinational unit takes a 128-bit data operand, a 128-bit control operand and the current contents of the destination, and produces a 128-bit result selected by an 11-bit operation code. Six operations are supported. Three rotate the data operand left: plain, ANDed with a generated mask, or merged into the old destination under that mask. Three shift it: left logical, right logical and right arithmetic.

All amounts come from packed fields inside the upper 64-bit half of the control operand: a 7-bit rotate or shift count, a 7-bit mask start and a 7-bit mask stop. The mask uses most-significant-first numbering and may wrap past the end of the word. An operation code outside the six known values raises a flag and forces the result to zero. The unit is meant to sit in an execution pipeline stage between operand fetch and writeback, so it adds no registers of its own.

Top module: `rsm_unit`

## Requirements
- R1: The count is control bits [70:64], which are the low 7 bits of its upper doubleword. No other control bit affects a rotate or shift.
- R2: Code 0x005 returns the data operand rotated left by the count. Bits leaving bit 127 re-enter at bit 0.
- R3: The mask start is control bits [86:80] and the mask stop is control bits [78:72]. Position p in most-significant-first numbering is result bit 127-p. When start <= stop, the mask holds ones at positions start through stop inclusive.
- R4: When start > stop, the mask wraps. It holds ones at positions start through 127 and at positions 0 through stop, and zeros elsewhere.
- R5: Code 0x145 returns the rotated data operand ANDed with the mask.
- R6: Code 0x045 returns (rotated data AND mask) OR (old destination AND NOT mask).
- R7: Code 0x105 shifts the data operand left by the count and fills vacated low bits with zero.
- R8: Code 0x205 shifts the data operand right by the count and fills vacated high bits with zero.
- R9: Code 0x305 shifts the data operand right by the count and fills vacated high bits with the data operand's bit 127.
- R10: A count of zero returns the data operand unchanged for 0x005, 0x105, 0x205 and 0x305, with no sign fill.
- R11: Any other code drives `illegal` high and the result to all zeros. The six codes above drive `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 128 | Data operand to be rotated or shifted |
| op_b | input | 128 | Control operand carrying count, mask start and mask stop |
| prev_t | input | 128 | Current destination contents, used by the insert form |
| opcode | input | 11 | Operation select |
| result | output | 128 | Operation result |
| illegal | output | 1 | High when the operation code is not recognised |

## Verification
The unit holds no state, so any internal fault shows on `result` in the same cycle its inputs are applied. The likely faults are a misplaced field slice, a mask built with the wrong bit order or without wrap, and a sign fill applied on a zero count. Each of these corrupts specific result bits as soon as a vector touches the affected field value. For that reason the bench pairs directed corner vectors with random ones. The corner vectors cover zero count, count 127, start equal to stop, full wrap and a negative data operand. Each result is compared against an independent bit-loop model.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int DATA_W = 128;
  localparam int OPC_W  = 11;

  typedef enum logic [OPC_W-1:0] {
    OPC_ROTL  = 11'h005,
    OPC_RINS  = 11'h045,
    OPC_RAND  = 11'h145,
    OPC_SHL   = 11'h105,
    OPC_SHR   = 11'h205,
    OPC_SRA   = 11'h305
  } rsm_opc_e;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RLOG  = 2'd1,
    SK_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/rsm_fields.sv
module rsm_fields #(
  parameter int DW      = 128,
  parameter int AW      = $clog2(DW),
  parameter int CNT_LSB = 64,
  parameter int BEG_LSB = 80,
  parameter int END_LSB = 72
) (
  input  logic [DW-1:0] ctl_i,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] beg_o,
  output logic [AW-1:0] end_o
);
  assign cnt_o = ctl_i[CNT_LSB +: AW];
  assign beg_o = ctl_i[BEG_LSB +: AW];
  assign end_o = ctl_i[END_LSB +: AW];
endmodule

// File: rtl/rsm_maskgen.sv
module rsm_maskgen #(
  parameter int DW = 128,
  parameter int AW = $clog2(DW)
) (
  input  logic [AW-1:0] beg_i,
  input  logic [AW-1:0] end_i,
  output logic [DW-1:0] mask_o
);
  logic wrap;
  assign wrap = beg_i > end_i;

  // position p counts from the most significant bit
  for (genvar p = 0; p < DW; p++) begin : g_pos
    logic ge_beg, le_end;
    assign ge_beg = AW'(p) >= beg_i;
    assign le_end = AW'(p) <= end_i;
    assign mask_o[DW-1-p] = wrap ? (ge_beg | le_end) : (ge_beg & le_end);
  end

  always_comb begin
    a_r3_ends_set: assert (mask_o[DW-1-int'(beg_i)] && mask_o[DW-1-int'(end_i)])
      else $error("mask boundary bit clear");
  end
endmodule

// File: rtl/rsm_shifter.sv
module rsm_shifter
  import rsm_pkg::*;
#(
  parameter int DW = 128,
  parameter int AW = $clog2(DW)
) (
  input  logic [DW-1:0] a_i,
  input  logic [AW-1:0] cnt_i,
  input  shift_kind_e   kind_i,
  output logic [DW-1:0] rot_o,
  output logic [DW-1:0] shf_o
);
  function automatic logic [DW-1:0] rotl_f(input logic [DW-1:0] v, input logic [AW-1:0] s);
    logic [AW:0] back;
    back = (AW+1)'(DW) - {1'b0, s};
    if (s == '0) return v;
    return (v << s) | (v >> back);
  endfunction

  function automatic logic [DW-1:0] shift_f(input logic [DW-1:0] v, input logic [AW-1:0] s,
                                            input shift_kind_e k);
    case (k)
      SK_LEFT: return v << s;
      SK_RLOG: return v >> s;
      default: return DW'($signed(v) >>> s);
    endcase
  endfunction

  assign rot_o = rotl_f(a_i, cnt_i);
  assign shf_o = shift_f(a_i, cnt_i, kind_i);

  always_comb begin
    if (cnt_i == '0) begin
      a_r10_zero_count: assert (rot_o == a_i && shf_o == a_i)
        else $error("zero count altered operand");
    end
    if (kind_i == SK_RARI && cnt_i != '0) begin
      a_r9_sign_fill: assert (shf_o[DW-1] == a_i[DW-1])
        else $error("arithmetic shift lost sign");
    end
  end
endmodule

// File: rtl/rsm_unit.sv
module rsm_unit
  import rsm_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int OW      = OPC_W,
  parameter int CNT_LSB = 64,
  parameter int BEG_LSB = 80,
  parameter int END_LSB = 72
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] prev_t,
  input  logic [OW-1:0] opcode,
  output logic [DW-1:0] result,
  output logic          illegal
);
  localparam int AW = $clog2(DW);

  logic [AW-1:0] cnt, mbeg, mend;
  logic [DW-1:0] mask, rotated, shifted;
  shift_kind_e   kind;

  rsm_fields #(.DW(DW), .AW(AW), .CNT_LSB(CNT_LSB), .BEG_LSB(BEG_LSB), .END_LSB(END_LSB))
    u_fields (.ctl_i(op_b), .cnt_o(cnt), .beg_o(mbeg), .end_o(mend));

  rsm_maskgen #(.DW(DW), .AW(AW))
    u_mask (.beg_i(mbeg), .end_i(mend), .mask_o(mask));

  rsm_shifter #(.DW(DW), .AW(AW))
    u_shift (.a_i(op_a), .cnt_i(cnt), .kind_i(kind), .rot_o(rotated), .shf_o(shifted));

  always_comb begin
    case (opcode)
      OPC_SHR: kind = SK_RLOG;
      OPC_SRA: kind = SK_RARI;
      default: kind = SK_LEFT;
    endcase
  end

  always_comb begin
    illegal = 1'b0;
    case (opcode)
      OPC_ROTL: result = rotated;
      OPC_RAND: result = rotated & mask;
      OPC_RINS: result = (rotated & mask) | (prev_t & ~mask);
      OPC_SHL, OPC_SHR, OPC_SRA: result = shifted;
      default: begin
        result  = '0;
        illegal = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (illegal) begin
      a_r11_illegal_zero: assert (result == '0) else $error("illegal code gave data");
    end
    if (opcode == OPC_RINS) begin
      a_r6_insert_keeps: assert ((result & ~mask) == (prev_t & ~mask))
        else $error("insert disturbed bits outside mask");
    end
    if (opcode == OPC_RAND) begin
      a_r5_and_inside: assert ((result & ~mask) == '0)
        else $error("and-form set bits outside mask");
    end
  end
endmodule

// File: tb/tb_rsm_unit.sv
module tb_rsm_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [127:0] op_a, op_b, prev_t, result;
  logic [10:0]  opcode;
  logic         illegal;
  int n_vec = 0, n_bad = 0;

  rsm_unit dut (.op_a(op_a), .op_b(op_b), .prev_t(prev_t), .opcode(opcode),
                .result(result), .illegal(illegal));

  function automatic logic [127:0] pack_b(int amt, int mb, int me, logic [127:0] filler);
    logic [127:0] b = filler;
    for (int i = 0; i < 7; i++) begin
      b[64+i] = amt[i];
      b[80+i] = mb[i];
      b[72+i] = me[i];
    end
    return b;
  endfunction

  function automatic logic [127:0] ref_mask(int mb, int me);
    logic [127:0] m = '0;
    for (int p = 0; p < 128; p++) begin
      bit on;
      if (mb <= me) on = (p >= mb) && (p <= me);
      else          on = (p >= mb) || (p <= me);
      m[127-p] = on;
    end
    return m;
  endfunction

  function automatic logic [127:0] ref_rot(logic [127:0] a, int s);
    logic [127:0] r = '0;
    for (int i = 0; i < 128; i++) r[(i+s)%128] = a[i];
    return r;
  endfunction

  function automatic logic [128:0] ref_model(logic [127:0] a, logic [127:0] b,
                                             logic [127:0] t, logic [10:0] op);
    int s  = 0, mb = 0, me = 0;
    logic [127:0] r = '0, m;
    for (int i = 0; i < 7; i++) begin
      s[i] = b[64+i]; mb[i] = b[80+i]; me[i] = b[72+i];
    end
    m = ref_mask(mb, me);
    case (op)
      11'h005: r = ref_rot(a, s);
      11'h145: r = ref_rot(a, s) & m;
      11'h045: r = (ref_rot(a, s) & m) | (t & ~m);
      11'h105: for (int i = 0; i < 128; i++) r[i] = (i >= s) ? a[i-s] : 1'b0;
      11'h205: for (int i = 0; i < 128; i++) r[i] = (i+s < 128) ? a[i+s] : 1'b0;
      11'h305: for (int i = 0; i < 128; i++) r[i] = (i+s < 128) ? a[i+s] : a[127];
      default: return {1'b1, 128'd0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic apply(string tag, logic [127:0] a, logic [127:0] b,
                       logic [127:0] t, logic [10:0] op);
    logic [128:0] exp;
    @(posedge clk);
    op_a = a; op_b = b; prev_t = t; opcode = op;
    exp = ref_model(a, b, t, op);
    @(negedge clk);
    n_vec++;
    if ({illegal, result} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h actual=%b_%h expected=%b_%h", tag, op,
               illegal, result, exp[128], exp[127:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  localparam logic [127:0] PAT  = 128'h8123_4567_89ab_cdef_0f1e_2d3c_4b5a_6978;
  localparam logic [127:0] POS  = 128'h7fed_cba9_8765_4321_0011_2233_4455_6677;
  localparam logic [127:0] OLDT = 128'hdead_beef_cafe_f00d_1357_9bdf_2468_ace0;

  initial begin
    logic [10:0] ops [6] = '{11'h005, 11'h045, 11'h145, 11'h105, 11'h205, 11'h305};
    op_a = '0; op_b = '0; prev_t = '0; opcode = '0;
    // R11: idle code 0 is illegal
    apply("R11", PAT, '0, OLDT, 11'h000);
    apply("R11", PAT, pack_b(5, 0, 127, '1), OLDT, 11'h00B);
    apply("R11", PAT, '1, OLDT, 11'h405);
    apply("R11", PAT, '1, OLDT, 11'h7FF);
    // R2 rotate, R1 field position with junk elsewhere
    apply("R2", PAT, pack_b(1, 0, 0, '0), OLDT, 11'h005);
    apply("R2", PAT, pack_b(127, 0, 0, '0), OLDT, 11'h005);
    apply("R1", PAT, pack_b(37, 9, 90, ~128'h0), OLDT, 11'h005);
    apply("R1", PAT, pack_b(37, 9, 90, 128'h5555_0000_ffff_0000_1234), OLDT, 11'h105);
    // R10 zero count, including a negative operand under arithmetic shift
    apply("R10", PAT, pack_b(0, 3, 4, '1), OLDT, 11'h005);
    apply("R10", PAT, pack_b(0, 3, 4, '0), OLDT, 11'h105);
    apply("R10", PAT, pack_b(0, 3, 4, '0), OLDT, 11'h205);
    apply("R10", PAT, pack_b(0, 3, 4, '0), OLDT, 11'h305);
    // R3 masks, R4 wrap, R5 and, R6 insert
    apply("R3", '1, pack_b(0, 0, 0, '0), '0, 11'h145);
    apply("R3", '1, pack_b(0, 127, 127, '0), '0, 11'h145);
    apply("R3", '1, pack_b(0, 0, 127, '0), '0, 11'h145);
    apply("R3", '1, pack_b(0, 40, 71, '0), '0, 11'h145);
    apply("R4", '1, pack_b(0, 100, 20, '0), '0, 11'h145);
    apply("R4", '1, pack_b(0, 127, 0, '0), '0, 11'h145);
    apply("R4", '1, pack_b(0, 65, 64, '0), '0, 11'h145);
    apply("R5", PAT, pack_b(13, 8, 60, '0), OLDT, 11'h145);
    apply("R6", PAT, pack_b(13, 8, 60, '0), OLDT, 11'h045);
    apply("R6", PAT, pack_b(99, 110, 5, '0), OLDT, 11'h045);
    // R7, R8, R9 shifts at edges
    apply("R7", PAT, pack_b(127, 0, 0, '0), OLDT, 11'h105);
    apply("R7", PAT, pack_b(64, 0, 0, '0), OLDT, 11'h105);
    apply("R8", PAT, pack_b(127, 0, 0, '0), OLDT, 11'h205);
    apply("R8", PAT, pack_b(3, 0, 0, '0), OLDT, 11'h205);
    apply("R9", PAT, pack_b(127, 0, 0, '0), OLDT, 11'h305);
    apply("R9", PAT, pack_b(65, 0, 0, '0), OLDT, 11'h305);
    apply("R9", POS, pack_b(65, 0, 0, '0), OLDT, 11'h305);
    // random sweep across all six codes
    for (int k = 0; k < 600; k++) begin
      logic [127:0] ra, rb, rt;
      logic [10:0] op;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rt = {$urandom, $urandom, $urandom, $urandom};
      op = ops[$urandom_range(0, 5)];
      apply("R1/R2/R5/R6/R7/R8/R9", ra, rb, rt, op);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule